// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that fronts an internal byte memory of 256, 512, 1024 or 2048 bytes. It watches SCL and SDA through a short synchronizer running on the system clock. It drives SDA only by pulling it low through an output enable, because the bus line is open drain. A master selects the device with a slave address byte whose upper nibble is a fixed device-type code. The middle bits of that byte are compared with strap pins. Any of those middle bits not used by straps instead pick one 256-byte block of the memory.

Writes do not reach the memory directly. Up to sixteen data bytes are collected in a page buffer, and a STOP then starts a self-timed write cycle of a set number of system clocks. While that cycle runs, the device ignores its own address, so a master can poll it to find out when the write is done. A write-protect input keeps the whole memory unchanged. Reads return the byte at the internal address counter and continue through sequential addresses for as long as the master acknowledges.

Top module: `eep_slave`

## Requirements
- R1: After reset, and after every STOP, the block does not drive SDA (`sda_oe_o` low).
- R2: The block acknowledges a slave address byte only if bits 7..4 equal 1010 and bits 3..(1+B) equal the strap pins `dev_addr_i[2:B]`, where B = log2(NUM_BLOCKS). Otherwise it leaves SDA released until the next START.
- R3: For a write, slave address bits B..1 become the upper bits of the memory address, and the byte after the slave address gives the low eight bits. Bit 0 of the slave address byte is 1 for read and 0 for write.
- R4: Each byte the block receives while addressed is acknowledged by pulling SDA low during the ninth SCL pulse.
- R5: Data bytes of a write go to consecutive addresses whose low four bits wrap inside the 16-byte page, so a 17th byte replaces the first byte of the transfer.
- R6: A STOP after at least one buffered data byte, with write protect low, starts a write cycle of WRITE_CYCLES system clocks. The buffered bytes reach the memory when the cycle ends.
- R7: While a write cycle runs, the block does not acknowledge its slave address.
- R8: With `wp_i` high at the STOP, data bytes are still acknowledged but are discarded, no write cycle starts, and the memory keeps its old contents.
- R9: A read returns the byte at the address counter, and the counter then advances by one. A random read is set up by a write of the byte address followed by a repeated START. The counter wraps from the last byte of the memory to address 0.
- R10: When the master does not acknowledge a read byte, the block releases SDA and stops sending until the next START.
- R11: The block changes the level it drives on SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High to pull SDA low |
| dev_addr_i | input | 3 | Strap pins compared with slave address bits 3..1 |
| wp_i | input | 1 | Write protect: high keeps the memory unchanged |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or a STOP. They also assume that each SCL high and low phase lasts several system clocks longer than the synchronizer delay, so every edge and every bus condition is seen as a single event. The bench keeps within these limits by building all bus activity from one quarter-bit delay of eight system clocks. It changes SDA only in the middle of a low phase, and it picks random values only for block, byte address, burst length, data and write protect, never for timing.

// File: rtl/eep_pkg.sv
package eep_pkg;

   // bus-side phases of the slave
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADR,
      ST_WADR_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RACK
   } eep_state_e;

   localparam logic [3:0]  DEV_TYPE    = 4'b1010;
   localparam int unsigned PAGE_BYTES  = 16;
   localparam int unsigned BLOCK_BITS  = 8;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eep_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
   parameter int unsigned CYCLES = 600000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (start_i && left_q == '0)
         left_q <= CW'(CYCLES);
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);
   assign done_o = (left_q == CW'(1));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int unsigned AW    = 8,
   parameter int unsigned PAGE  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr_i,
   output logic [7:0]    rd_data_o,
   input  logic          buf_we_i,
   input  logic [AW-1:0] buf_addr_i,
   input  logic [7:0]    buf_data_i,
   input  logic          buf_clear_i,
   input  logic          commit_i,
   output logic          pending_o
);

   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned PW    = $clog2(PAGE);

   if (PAGE < 2 || (1 << PW) != PAGE || PW >= AW) begin : g_bad_page
      $error("eep_array: PAGE must be a power of two below the depth");
   end

   logic [7:0]       mem  [DEPTH];
   logic [7:0]       pbuf [PAGE];
   logic [PAGE-1:0]  pvalid_q;
   logic [AW-PW-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (commit_i) begin
         for (int p = 0; p < PAGE; p++)
            if (pvalid_q[p]) mem[{page_q, PW'(p)}] <= pbuf[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pvalid_q <= '0;
         page_q   <= '0;
      end else if (buf_clear_i || commit_i) begin
         pvalid_q <= '0;
      end else if (buf_we_i) begin
         pvalid_q[buf_addr_i[PW-1:0]] <= 1'b1;
         page_q                       <= buf_addr_i[AW-1:PW];
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we_i) pbuf[buf_addr_i[PW-1:0]] <= buf_data_i;
   end

   assign rd_data_o = mem[rd_addr_i];
   assign pending_o = |pvalid_q;

endmodule

// File: rtl/eep_slave.sv
module eep_slave
   import eep_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS   = 1,
   parameter int unsigned WRITE_CYCLES = 600000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] dev_addr_i,
   input  logic       wp_i
);

   localparam int unsigned BW = $clog2(NUM_BLOCKS);
   localparam int unsigned AW = BLOCK_BITS + BW;
   localparam int unsigned PW = $clog2(PAGE_BYTES);
   localparam logic [2:0]  STRAP_MASK = 3'b111 << BW;

   if (!(NUM_BLOCKS == 1 || NUM_BLOCKS == 2 || NUM_BLOCKS == 4 || NUM_BLOCKS == 8))
   begin : g_bad_blocks
      $error("eep_slave: NUM_BLOCKS must be 1, 2, 4 or 8");
   end
   if (WRITE_CYCLES < 2) begin : g_bad_cycles
      $error("eep_slave: WRITE_CYCLES must be at least 2");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

   eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_o     (scl_s),
      .sda_o     (sda_s),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (start_evt),
      .stop_o    (stop_evt)
   );

   eep_state_e     state_q;
   logic [3:0]     bit_cnt_q;
   logic [7:0]     shreg_q, dout_q;
   logic [AW-1:0]  addr_q, wadr_full;
   logic           rw_q, mack_q, sda_oe_q;

   logic           busy, wr_done, pending;
   logic [7:0]     rd_data;
   logic           byte_in, dev_hit, dev_take, buf_we, buf_clear, cycle_go;

   assign byte_in  = scl_fall && (bit_cnt_q == 4'd8);
   assign dev_hit  = (shreg_q[7:4] == DEV_TYPE) &&
                     (((shreg_q[3:1] ^ dev_addr_i) & STRAP_MASK) == 3'b000);
   assign dev_take = (state_q == ST_DEV) && byte_in && dev_hit && !busy;
   assign buf_we   = (state_q == ST_WDAT) && byte_in && !busy &&
                     !start_evt && !stop_evt;
   assign cycle_go = stop_evt && pending && !wp_i && !busy;
   assign buf_clear = !busy && (start_evt || (stop_evt && wp_i));

   // upper address bits come from the slave address when blocks exist
   if (BW == 0) begin : g_flat
      assign wadr_full = shreg_q;
   end else begin : g_blk
      logic [BW-1:0] blk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        blk_q <= '0;
         else if (dev_take) blk_q <= shreg_q[BW:1];
      end
      assign wadr_full = {blk_q, shreg_q};
   end

   eep_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(cycle_go),
      .busy_o (busy),
      .done_o (wr_done)
   );

   eep_array #(.AW(AW), .PAGE(PAGE_BYTES)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_addr_i  (addr_q),
      .rd_data_o  (rd_data),
      .buf_we_i   (buf_we),
      .buf_addr_i (addr_q),
      .buf_data_i (shreg_q),
      .buf_clear_i(buf_clear),
      .commit_i   (wr_done),
      .pending_o  (pending)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         dout_q    <= '0;
         addr_q    <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         sda_oe_q  <= 1'b0;
      end else if (stop_evt) begin
         state_q  <= ST_IDLE;
         sda_oe_q <= 1'b0;
      end else if (start_evt) begin
         state_q   <= ST_DEV;
         bit_cnt_q <= '0;
         sda_oe_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_DEV, ST_WADR, ST_WDAT: begin
               if (scl_rise) begin
                  shreg_q   <= {shreg_q[6:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end else if (byte_in) begin
                  if (state_q == ST_DEV) begin
                     if (dev_take) begin
                        sda_oe_q <= 1'b1;
                        rw_q     <= shreg_q[0];
                        state_q  <= ST_DEV_ACK;
                     end else begin
                        state_q  <= ST_IDLE;
                     end
                  end else if (state_q == ST_WADR) begin
                     sda_oe_q <= 1'b1;
                     state_q  <= ST_WADR_ACK;
                  end else begin
                     sda_oe_q <= 1'b1;
                     addr_q   <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
                     state_q  <= ST_WDAT_ACK;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (scl_fall) begin
                  bit_cnt_q <= '0;
                  if (rw_q) begin
                     dout_q   <= rd_data;
                     sda_oe_q <= ~rd_data[7];
                     state_q  <= ST_RDAT;
                  end else begin
                     sda_oe_q <= 1'b0;
                     state_q  <= ST_WADR;
                  end
               end
            end
            ST_WADR_ACK: begin
               if (scl_fall) begin
                  sda_oe_q  <= 1'b0;
                  bit_cnt_q <= '0;
                  addr_q    <= wadr_full;
                  state_q   <= ST_WDAT;
               end
            end
            ST_WDAT_ACK: begin
               if (scl_fall) begin
                  sda_oe_q  <= 1'b0;
                  bit_cnt_q <= '0;
                  state_q   <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end else if (scl_fall) begin
                  if (bit_cnt_q == 4'd8) begin
                     sda_oe_q <= 1'b0;
                     addr_q   <= addr_q + 1'b1;
                     state_q  <= ST_RACK;
                  end else begin
                     dout_q   <= {dout_q[6:0], 1'b0};
                     sda_oe_q <= ~dout_q[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     bit_cnt_q <= '0;
                     dout_q    <= rd_data;
                     sda_oe_q  <= ~rd_data[7];
                     state_q   <= ST_RDAT;
                  end else begin
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = sda_oe_q;

endmodule

// File: rtl/eep_slave_sva.sv
module eep_slave_sva
   import eep_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 600000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       busy,
   input logic       wp_i,
   input logic       stop_evt,
   input eep_state_e state
);

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   a_r1_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   a_r11_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   a_r7_busy_no_dev_ack: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (state != ST_DEV_ACK));

   a_r8_wp_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i));

   a_r6_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= WRITE_CYCLES);

   a_r6_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == WRITE_CYCLES));

endmodule

bind eep_slave eep_slave_sva #(.WRITE_CYCLES(WRITE_CYCLES)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_s),
   .sda_oe  (sda_oe_o),
   .busy    (busy),
   .wp_i    (wp_i),
   .stop_evt(stop_evt),
   .state   (state_q)
);

// File: tb/eep_slave_tb.sv
module eep_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int NB         = 2;
   localparam int WCYC       = 300;
   localparam int MSIZE      = NB * 256;
   localparam logic [2:0] STRAP = 3'b100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_bus;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_PERIOD / 2) clk = ~clk;

   eep_slave #(.NUM_BLOCKS(NB), .WRITE_CYCLES(WCYC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_bus),
      .sda_oe_o  (sda_oe),
      .dev_addr_i(STRAP),
      .wp_i      (wp)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [7:0] mdl [MSIZE];
   int mptr = 0;
   logic [7:0] wbuf [20];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitq(input int k = 1);
      repeat (k * Q) @(negedge clk);
   endtask

   function automatic logic [7:0] dev(input int blk, input bit rd);
      return {4'b1010, STRAP[2:1], blk[0], rd};
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; waitq(); scl = 1'b1; waitq(); sda_m = 1'b0; waitq(); scl = 1'b0; waitq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq(); scl = 1'b1; waitq(); sda_m = 1'b1; waitq();
   endtask

   task automatic put_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; waitq(); scl = 1'b1; waitq(2); scl = 1'b0; waitq();
      end
      sda_m = 1'b1; waitq(); scl = 1'b1; waitq();
      ack = !sda_bus;
      waitq(); scl = 1'b0; waitq();
   endtask

   task automatic get_byte(input bit ackit, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         waitq(); scl = 1'b1; waitq(); b[i] = sda_bus; waitq(); scl = 1'b0; waitq();
      end
      sda_m = ackit ? 1'b0 : 1'b1;
      waitq(); scl = 1'b1; waitq(2); scl = 1'b0; waitq();
      sda_m = 1'b1;
   endtask

   // address poll after a write; expects busy first when a cycle was started
   task automatic poll(input bit expect_cycle);
      bit a;
      bus_start(); put_byte(dev(0, 0), a); bus_stop();
      if (expect_cycle) begin
         chk(!a, "R7 address ignored while busy", a, 0);
         for (int k = 0; k < 8 && !a; k++) begin
            bus_start(); put_byte(dev(0, 0), a); bus_stop();
         end
         chk(a, "R6 write cycle ends", a, 1);
      end else begin
         chk(a, "R8 no write cycle under protect", a, 1);
      end
   endtask

   task automatic write_txn(input int blk, input int adr, input int n);
      bit a;
      int base;
      bit prot;
      prot = wp;
      base = blk * 256 + (adr & 8'hF0);
      bus_start();
      put_byte(dev(blk, 0), a); chk(a, "R4 slave address ack", a, 1);
      put_byte(adr[7:0], a);    chk(a, "R4 byte address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         put_byte(wbuf[i], a);
         chk(a, prot ? "R8 data ack under protect" : "R4 data ack", a, 1);
         if (!prot) mdl[base + ((adr + i) & 15)] = wbuf[i];
      end
      mptr = base + ((adr + n) & 15);
      bus_stop();
      poll(!prot);
   endtask

   task automatic read_bytes(input int n, input string req);
      logic [7:0] b;
      for (int i = 0; i < n; i++) begin
         get_byte(i < n - 1, b);
         chk(b == mdl[mptr], req, b, mdl[mptr]);
         mptr = (mptr + 1) % MSIZE;
      end
      chk(sda_bus == 1'b1, "R10 released after master nack", sda_bus, 1);
      bus_stop();
   endtask

   task automatic read_rand(input int blk, input int adr, input int n, input string req);
      bit a;
      bus_start();
      put_byte(dev(blk, 0), a); chk(a, "R3 dummy write ack", a, 1);
      put_byte(adr[7:0], a);    chk(a, "R3 address ack", a, 1);
      bus_start();
      put_byte(dev(blk, 1), a); chk(a, "R9 read address ack", a, 1);
      mptr = blk * 256 + adr;
      read_bytes(n, req);
   endtask

   task automatic read_cur(input int n, input string req);
      bit a;
      bus_start();
      put_byte(dev(0, 1), a); chk(a, "R9 current read ack", a, 1);
      read_bytes(n, req);
   endtask

   initial begin
      bit a;
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < MSIZE; i++) mdl[i] = '0;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

      // R2: wrong type code, then wrong strap bits
      bus_start(); put_byte(8'b1011_1000, a); bus_stop();
      chk(!a, "R2 wrong type ignored", a, 0);
      bus_start(); put_byte(8'b1010_0100, a); bus_stop();
      chk(!a, "R2 wrong strap ignored", a, 0);
      chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);

      // R3: same byte address in both blocks holds distinct data
      wbuf[0] = 8'h5A; write_txn(0, 8'h10, 1);
      wbuf[0] = 8'hC3; write_txn(1, 8'h10, 1);
      read_rand(0, 8'h10, 1, "R3 block 0 data");
      read_rand(1, 8'h10, 1, "R3 block 1 data");

      // R5: full page, then 17 bytes wrapping from mid page
      for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h80 + i);
      write_txn(1, 8'h30, 16);
      read_rand(1, 8'h30, 16, "R5 page write readback");
      for (int i = 0; i < 17; i++) wbuf[i] = 8'(8'h20 + 3 * i);
      write_txn(0, 8'h45, 17);
      read_rand(0, 8'h40, 16, "R5 wrap overwrites first byte");

      // R9: current address read continues after the last read
      read_cur(2, "R9 current address read");

      // R8: protected write leaves old data
      wp = 1'b1;
      for (int i = 0; i < 4; i++) wbuf[i] = 8'hEE;
      write_txn(0, 8'h10, 4);
      wp = 1'b0;
      read_rand(0, 8'h10, 4, "R8 memory unchanged");

      // R9: rollover from the last byte to address 0
      read_rand(1, 8'hFF, 2, "R9 rollover at array end");

      // random mix of blocks, offsets, lengths and protection
      for (int it = 0; it < 6; it++) begin
         int blk, adr, n;
         blk = $urandom % NB;
         adr = $urandom % 256;
         n   = 1 + ($urandom % 16);
         for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
         wp = (($urandom % 4) == 0);
         write_txn(blk, adr, n);
         wp = 1'b0;
         read_rand(blk, adr & 8'hF0, 16, "R5 R9 random page readback");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule